// File: doc/BRIEF.md
# Decimal Sixes Correction Generator

This block serves packed-decimal addition built on a binary adder. It adds two 64-bit operands in binary and finds the carry out of each 4-bit digit lane. It then returns a correction word. That word holds 6 in every lane that carried nothing out and 0 in every lane that carried out. A later stage uses the word to fix up the binary sum into decimal digits. That later stage, and any check that the inputs hold legal decimal digits, are outside this block.

The carries are not computed lane by lane. A single wide add runs over 65 bits, and the top bit keeps the final carry. XORing that sum with the carry-less sum (a XOR b) gives the carry into every bit position. The vector is then moved down by one lane, so the carry out of lane k sits at bit 4k. The carry out of the top lane comes from bit 64. The inverted lane carries are masked to the low bit of each lane and multiplied by six, using only shifts and an add inside each lane. The result can be registered behind a valid strobe, or left purely combinational.

Top module: `sixes_corr_gen`

## Requirements
- R1: While rst_ni is low, and right after it is released, valid_o is 0 and corr_o is all zeros.
- R2: Lane k of corr_o covers bits 4k+3..4k. It is 4'h6 when lane k of a_i+b_i, with the carry from lane k-1 included, carries nothing out, and 4'h0 when it carries out.
- R3: A carry that ripples through lanes holding 0xF sends a carry out of each of those lanes. For example, 0x0FFF + 0x1 gives 0 in lanes 0 to 2 and 6 in every lane above them.
- R4: The carry out of the top lane (bit 64 of the 65-bit sum) counts like any other lane carry: 0x8000_0000_0000_0000 + 0x8000_0000_0000_0000 gives 0x0666_6666_6666_6666.
- R5: Two all-zero operands give 0x6666_6666_6666_6666.
- R6: Two all-ones operands give 0.
- R7: With the default OUT_REG=1, valid_o is valid_i delayed by one clock, and corr_o then holds the result for the operands sampled on that edge.
- R8: On an edge where valid_i is low, the operands are ignored: corr_o keeps its value and valid_o is 0.
- R9: Every lane of corr_o is always either 4'h0 or 4'h6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand strobe |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result strobe |
| corr_o | output | 64 | Correction word, 6 or 0 per lane |

## Verification
All-zero operands make every lane correction-free, and all-ones operands make every lane carry. Together they confirm that the lane mask and the times-six step work at both extremes. A ripple chain of 0xF lanes shows that a carry coming in from below, and not only a local overflow, clears a lane. Operands with only the top lanes set check that the 65th sum bit reaches the top lane. Random operand pairs, compared against a lane-by-lane decimal reference adder, mix all of these. Idle cycles that carry changing garbage operands confirm that the result only updates on strobed edges.

// File: rtl/sixes_corr_pkg.sv
package sixes_corr_pkg;
  localparam int unsigned NIB_W = 4;

  // word with a 1 in the low bit of every lane
  function automatic logic [63:0] lane_lsb_mask(input int unsigned width);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = 0; i < width; i += NIB_W) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic lanes_are_0_or_6(input logic [63:0] w, input int unsigned width);
    logic ok;
    ok = 1'b1;
    for (int unsigned i = 0; i < width; i += NIB_W)
      if (w[i +: NIB_W] != 4'h0 && w[i +: NIB_W] != 4'h6) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/sixes_carry_extract.sv
module sixes_carry_extract
  import sixes_corr_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] lane_carry_o  // bit 4k = carry out of lane k
);
  logic [DATA_W:0] sum_full;
  logic [DATA_W:0] carry_in_vec;

  assign sum_full     = {1'b0, a_i} + {1'b0, b_i};
  assign carry_in_vec = sum_full ^ {1'b0, a_i ^ b_i};
  assign lane_carry_o = {{(NIB_W-1){1'b0}}, carry_in_vec[DATA_W:NIB_W]};

  logic unused_low;
  assign unused_low = ^carry_in_vec[NIB_W-1:0];
endmodule

// File: rtl/sixes_lane_gen.sv
module sixes_lane_gen
  import sixes_corr_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] lane_carry_i,
  output logic [DATA_W-1:0] corr_o
);
  localparam int unsigned NIBS = DATA_W / NIB_W;
  localparam logic [DATA_W-1:0] LSB_MASK = DATA_W'(lane_lsb_mask(DATA_W));

  logic [DATA_W-1:0] marked;
  assign marked = ~lane_carry_i & LSB_MASK;

  // times six per lane: each lane holds 0 or 1, so no lane overflows
  for (genvar k = 0; k < NIBS; k++) begin : g_lane
    logic [NIB_W-1:0] m;
    assign m = marked[k*NIB_W +: NIB_W];
    assign corr_o[k*NIB_W +: NIB_W] = (m << 2) + (m << 1);
  end
endmodule

// File: rtl/sixes_out_stage.sv
module sixes_out_stage #(
  parameter int unsigned DATA_W  = 64,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        data_o  <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) data_o <= data_i;
      end
    end

    assert_valid_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    assert_idle_no_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(data_o));
    assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> data_o == $past(data_i));
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end
endmodule

// File: rtl/sixes_corr_gen.sv
module sixes_corr_gen
  import sixes_corr_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] corr_o
);
  localparam int unsigned NIBS = DATA_W / NIB_W;
  localparam int unsigned TOP  = (NIBS - 1) * NIB_W;

  logic [DATA_W-1:0] lane_carry;
  logic [DATA_W-1:0] corr_c;

  sixes_carry_extract #(.DATA_W(DATA_W)) u_carry (
    .a_i          (a_i),
    .b_i          (b_i),
    .lane_carry_o (lane_carry)
  );

  sixes_lane_gen #(.DATA_W(DATA_W)) u_lanes (
    .lane_carry_i (lane_carry),
    .corr_o       (corr_c)
  );

  sixes_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (corr_c),
    .valid_o (valid_o),
    .data_o  (corr_o)
  );

  // top-lane carry must match unsigned overflow of the full add
  assert_top_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> lane_carry[TOP] == (a_i > ~b_i));
  assert_low_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> lane_carry[0] == ((5'(a_i[3:0]) + 5'(b_i[3:0])) > 5'd15));
  assert_all_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_i == '0 && b_i == '0) |-> corr_c == DATA_W'({16{4'h6}}));
  assert_all_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_i == '1 && b_i == '1) |-> corr_c == '0);
  assert_lane_values_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lanes_are_0_or_6(64'(corr_o), DATA_W));
endmodule

// File: tb/sim_sixes_corr_gen.sv
`timescale 1ns/1ps
module sim_sixes_corr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] corr_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  sixes_corr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .corr_o(corr_o)
  );

  function automatic logic [63:0] ref_corr(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic        c;
    logic [4:0]  s;
    c = 1'b0;
    for (int k = 0; k < 16; k++) begin
      s = 5'(a[4*k +: 4]) + 5'(b[4*k +: 4]) + 5'(c);
      c = s > 5'd15;
      r[4*k +: 4] = c ? 4'h0 : 4'h6;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b, input string req);
    @(negedge clk);
    a_i = a; b_i = b; valid_i = 1'b1;
    exp_q.push_back(ref_corr(a, b));
    tag_q.push_back(req);
  endtask

  // monitor: compare each strobed result against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R7", corr_o, 64'h0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(corr_o == e, t, corr_o, e);
        check(lanes_ok(corr_o), "R9", corr_o, e);
      end
    end
  end

  function automatic bit lanes_ok(input logic [63:0] w);
    for (int k = 0; k < 16; k++)
      if (w[4*k +: 4] != 4'h0 && w[4*k +: 4] != 4'h6) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && corr_o == '0, "R1", {63'b0, valid_o} | corr_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0 && corr_o == '0, "R1", {63'b0, valid_o} | corr_o, 64'h0);

    send(64'h0, 64'h0, "R5");
    send('1, '1, "R6");
    send(64'h0000_0000_0000_0FFF, 64'h1, "R3");
    send('1, 64'h1, "R3");
    send(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R4");
    send(64'hF000_0000_0000_0000, 64'h1000_0000_0000_0000, "R4");
    send(64'h1234_5678_9999_0909, 64'h0987_6543_0001_0707, "R2");
    send(64'h0000_0000_0000_0009, 64'h0000_0000_0000_0007, "R2");
    for (int i = 0; i < 200; i++)
      send({$urandom, $urandom}, {$urandom, $urandom}, "R2");
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R8: garbage operands without a strobe leave the result untouched
    begin
      logic [63:0] held;
      held = corr_o;
      for (int i = 0; i < 5; i++) begin
        a_i = {$urandom, $urandom} | 64'hF;
        b_i = 64'hF;
        @(negedge clk);
        check(corr_o == held, "R8", corr_o, held);
        check(valid_o == 1'b0, "R8", {63'b0, valid_o}, 64'h0);
      end
    end

    // R7: a single strobe gives exactly one valid cycle
    send(64'h0, 64'h0, "R7");
    @(negedge clk);
    valid_i = 1'b0;
    check(valid_o == 1'b1, "R7", {63'b0, valid_o}, 64'h1);
    @(negedge clk);
    check(valid_o == 1'b0, "R7", {63'b0, valid_o}, 64'h0);
    check(exp_q.size() == 0, "R7", 64'(exp_q.size()), 64'h0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule